// File: doc/BRIEF.md
# Predicated Stateful Accumulator Atom

This block is one stateful processing element in a packet pipeline. It keeps a single local state register that no other element can reach. It accepts one packet header vector per clock, marked by a valid bit. For every valid packet it tests a configurable predicate. The predicate compares either the current state or packet field A against a constant.

The result of the predicate picks one of two update paths. Each path is an adder fed by two multiplexers. One multiplexer chooses the base term: the current state or zero. The other chooses the addend: a constant or a packet field. The true path takes its addend from field A and the false path from field B. The read, the compare, the add and the write-back of the state all complete within a single cycle, so packets can arrive back to back without losing an update.

Each packet also leaves one cycle later with a result field. That field carries one of four things, chosen by configuration:
- zero;
- the state before the update;
- the state after the update;
- a sample, which is field A when the predicate held and zero otherwise.

This lets one atom act as an accumulator, a wrapping counter or a 1-in-N sampler.

Top module: `pred_accum_atom`

## Requirements
- R1: After reset the state is 0, `out_valid` is 0 and `out_field` is 0.
- R2: The predicate compares the left operand with `cfg_cmp_k`. The left operand is the state when `cfg_cmp_pkt`=0 and `pkt_a` when it is 1. The unsigned compare is chosen by `cfg_cmp_op`: 0 equal, 1 not-equal, 2 less-than, 3 greater-or-equal.
- R3: When the predicate is true, the new state is base + addend. The base is the state when `cfg_t_keep`=1 and zero when it is 0. The addend is `pkt_a` when `cfg_t_pkt`=1 and `cfg_t_k` when it is 0.
- R4: When the predicate is false, the new state is base + addend. The base is the state when `cfg_f_keep`=1 and zero when it is 0. The addend is `pkt_b` when `cfg_f_pkt`=1 and `cfg_f_k` when it is 0.
- R5: On a cycle with `in_valid`=0 the state is unchanged. On the following cycle `out_valid` is 0 and `out_field` is 0.
- R6: `out_valid` equals `in_valid` of the previous cycle. Each packet's result appears exactly one cycle after it is presented.
- R7: Back-to-back valid packets each see the state left by the packet before them, and no update is lost.
- R8: `out_field` is selected by `cfg_out_sel`: 0 gives zero, 1 gives the state before the update, 2 gives the state after the update, 3 gives the sample (`pkt_a` if the predicate held, else 0).
- R9: The block can be configured as a wrapping counter that counts 0,1,…,L and then returns to 0, where L is the limit.
- R10: The block can be configured as a sampler. A packet that finds the state at 9 has `pkt_a` copied out and clears the state. Every other packet outputs 0 and increments the state.
- R11: Addition wraps modulo 2^W, where W is the data width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet present this cycle |
| pkt_a | input | W | Packet field A (true addend, compare operand, sample source) |
| pkt_b | input | W | Packet field B (false addend) |
| cfg_cmp_op | input | 2 | Compare: 0 eq, 1 ne, 2 lt, 3 ge |
| cfg_cmp_pkt | input | 1 | Compare left operand: 0 state, 1 pkt_a |
| cfg_cmp_k | input | W | Compare constant |
| cfg_t_keep | input | 1 | True path base: 1 state, 0 zero |
| cfg_t_pkt | input | 1 | True path addend: 1 pkt_a, 0 constant |
| cfg_t_k | input | W | True path constant |
| cfg_f_keep | input | 1 | False path base: 1 state, 0 zero |
| cfg_f_pkt | input | 1 | False path addend: 1 pkt_b, 0 constant |
| cfg_f_k | input | W | False path constant |
| cfg_out_sel | input | 2 | Output: 0 zero, 1 old state, 2 new state, 3 sample |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_field | output | W | Result field |

## Verification
Both the state and the result field are registered on the same edge that accepts a packet. Every result is therefore due exactly one cycle after its packet is presented. The bench drives each packet on a falling edge and checks its result on the next falling edge, half a cycle after the capturing rising edge. The state is observed only through the new-state and old-state output modes. In those modes a stall's effect, or the lack of one, shows up in the very next packet's result. Runs of back-to-back packets in counter and sampler modes show that every packet saw its predecessor's update.

// File: rtl/pred_accum_atom.sv
module pred_accum_atom #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] pkt_a,
  input  logic [W-1:0] pkt_b,
  input  logic [1:0]   cfg_cmp_op,
  input  logic         cfg_cmp_pkt,
  input  logic [W-1:0] cfg_cmp_k,
  input  logic         cfg_t_keep,
  input  logic         cfg_t_pkt,
  input  logic [W-1:0] cfg_t_k,
  input  logic         cfg_f_keep,
  input  logic         cfg_f_pkt,
  input  logic [W-1:0] cfg_f_k,
  input  logic [1:0]   cfg_out_sel,
  output logic         out_valid,
  output logic [W-1:0] out_field
);

  localparam logic [1:0] CMP_EQ = 2'd0, CMP_NE = 2'd1, CMP_LT = 2'd2, CMP_GE = 2'd3;
  localparam logic [1:0] OUT_ZERO = 2'd0, OUT_OLD = 2'd1, OUT_NEW = 2'd2, OUT_SMP = 2'd3;

  logic [W-1:0] state_q;
  logic [W-1:0] lhs, sum_t, sum_f, nxt, res;
  logic         pred;

  assign lhs = cfg_cmp_pkt ? pkt_a : state_q;

  always_comb begin
    case (cfg_cmp_op)
      CMP_EQ:  pred = (lhs == cfg_cmp_k);
      CMP_NE:  pred = (lhs != cfg_cmp_k);
      CMP_LT:  pred = (lhs <  cfg_cmp_k);
      default: pred = (lhs >= cfg_cmp_k);
    endcase
  end

  assign sum_t = (cfg_t_keep ? state_q : '0) + (cfg_t_pkt ? pkt_a : cfg_t_k);
  assign sum_f = (cfg_f_keep ? state_q : '0) + (cfg_f_pkt ? pkt_b : cfg_f_k);
  assign nxt   = pred ? sum_t : sum_f;

  always_comb begin
    case (cfg_out_sel)
      OUT_ZERO: res = '0;
      OUT_OLD:  res = state_q;
      OUT_NEW:  res = nxt;
      default:  res = pred ? pkt_a : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= '0;
      out_valid <= 1'b0;
      out_field <= '0;
    end else begin
      out_valid <= in_valid;
      out_field <= in_valid ? res : '0;
      if (in_valid) state_q <= nxt;
    end
  end

  assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && out_field == '0));

  assert_state_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(state_q));

  assert_new_matches_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_out_sel == OUT_NEW) |=> (out_field == state_q));

  assert_old_is_prior_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_out_sel == OUT_OLD) |=> (out_field == $past(state_q)));

  assert_sample_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_out_sel == OUT_SMP && !pred) |=> (out_field == '0));

  assert_cmp_codes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_cmp_op == CMP_NE && !cfg_cmp_pkt && state_q == cfg_cmp_k
     && !cfg_f_keep && !cfg_f_pkt) |=> (state_q == $past(cfg_f_k)));

endmodule

// File: tb/pred_accum_atom_tb.sv
module pred_accum_atom_tb;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [W-1:0] pkt_a = '0, pkt_b = '0, cfg_cmp_k = '0, cfg_t_k = '0, cfg_f_k = '0;
  logic [1:0] cfg_cmp_op = '0, cfg_out_sel = '0;
  logic cfg_cmp_pkt = 0, cfg_t_keep = 0, cfg_t_pkt = 0, cfg_f_keep = 0, cfg_f_pkt = 0;
  logic out_valid;
  logic [W-1:0] out_field;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pred_accum_atom #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pkt_a(pkt_a), .pkt_b(pkt_b),
    .cfg_cmp_op(cfg_cmp_op), .cfg_cmp_pkt(cfg_cmp_pkt), .cfg_cmp_k(cfg_cmp_k),
    .cfg_t_keep(cfg_t_keep), .cfg_t_pkt(cfg_t_pkt), .cfg_t_k(cfg_t_k),
    .cfg_f_keep(cfg_f_keep), .cfg_f_pkt(cfg_f_pkt), .cfg_f_k(cfg_f_k),
    .cfg_out_sel(cfg_out_sel), .out_valid(out_valid), .out_field(out_field));

  typedef struct packed {
    logic [1:0] op; logic ps; logic [7:0] k;
    logic bt; logic at; logic [7:0] kt;
    logic bf; logic af; logic [7:0] kf;
    logic [7:0] a; logic [7:0] b; logic [1:0] os; logic [7:0] ex;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{2'd2,1'b0,8'd100, 1'b1,1'b1,8'd0, 1'b1,1'b1,8'd0, 8'd5, 8'd7, 2'd2, 8'd5},
    '{2'd2,1'b0,8'd100, 1'b1,1'b1,8'd0, 1'b1,1'b1,8'd0, 8'd10,8'd7, 2'd2, 8'd15},
    '{2'd3,1'b0,8'd15,  1'b0,1'b0,8'd3, 1'b1,1'b1,8'd0, 8'd1, 8'd1, 2'd2, 8'd3},
    '{2'd0,1'b1,8'd4,   1'b1,1'b0,8'd2, 1'b1,1'b1,8'd0, 8'd4, 8'd20,2'd2, 8'd5},
    '{2'd0,1'b1,8'd4,   1'b1,1'b0,8'd2, 1'b1,1'b1,8'd0, 8'd6, 8'd20,2'd2, 8'd25},
    '{2'd1,1'b0,8'd25,  1'b1,1'b1,8'd0, 1'b0,1'b0,8'd9, 8'd3, 8'd3, 2'd2, 8'd9},
    '{2'd2,1'b0,8'd100, 1'b1,1'b1,8'd0, 1'b1,1'b1,8'd0, 8'd1, 8'd0, 2'd1, 8'd9},
    '{2'd3,1'b1,8'd50,  1'b1,1'b1,8'd0, 1'b0,1'b0,8'd0, 8'd50,8'd0, 2'd2, 8'd60},
    '{2'd2,1'b1,8'd50,  1'b1,1'b0,8'd1, 1'b0,1'b0,8'd0, 8'd49,8'd0, 2'd2, 8'd61},
    '{2'd0,1'b0,8'd0,   1'b0,1'b0,8'd0, 1'b1,1'b0,8'd4, 8'd0, 8'd0, 2'd0, 8'd0},
    '{2'd1,1'b0,8'd0,   1'b1,1'b0,8'd0, 1'b0,1'b0,8'd0, 8'd0, 8'd0, 2'd2, 8'd65},
    '{2'd0,1'b0,8'd65,  1'b0,1'b0,8'd0, 1'b1,1'b1,8'd0, 8'd77,8'd0, 2'd3, 8'd77},
    '{2'd0,1'b0,8'd0,   1'b1,1'b1,8'd0, 1'b0,1'b0,8'd0, 8'd0, 8'd0, 2'd2, 8'd0}
  };

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] op, input logic ps, input logic [W-1:0] k,
                     input logic bt, input logic at, input logic [W-1:0] kt,
                     input logic bf, input logic af, input logic [W-1:0] kf,
                     input logic [1:0] os);
    cfg_cmp_op = op; cfg_cmp_pkt = ps; cfg_cmp_k = k;
    cfg_t_keep = bt; cfg_t_pkt = at; cfg_t_k = kt;
    cfg_f_keep = bf; cfg_f_pkt = af; cfg_f_k = kf; cfg_out_sel = os;
  endtask

  task automatic pkt(input logic v, input logic [W-1:0] a, input logic [W-1:0] b);
    in_valid = v; pkt_a = a; pkt_b = b;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic clear_state();
    cfg(2'd0, 1'b1, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 2'd0);
    pkt(1'b1, '0, '0);
  endtask

  initial begin
    logic [W-1:0] s;
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", {{(W-1){1'b0}}, out_valid}, '0);
    check("R1 out_field after reset", out_field, '0);
    rst_n = 1;
    cfg(2'd0, 1'b1, '0, 1'b1, 1'b0, '0, 1'b1, 1'b0, '0, 2'd1);
    pkt(1'b1, '0, '0);
    check("R1 state zero after reset", out_field, '0);

    for (int i = 0; i < NV; i++) begin
      cfg(TBL[i].op, TBL[i].ps, W'(TBL[i].k), TBL[i].bt, TBL[i].at, W'(TBL[i].kt),
          TBL[i].bf, TBL[i].af, W'(TBL[i].kf), TBL[i].os);
      pkt(1'b1, W'(TBL[i].a), W'(TBL[i].b));
      check($sformatf("R6 vector %0d valid", i), {{(W-1){1'b0}}, out_valid}, 1);
      check($sformatf("R2/R3/R4/R8 vector %0d", i), out_field, W'(TBL[i].ex));
    end

    cfg(2'd0, 1'b1, '0, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, 2'd2);
    pkt(1'b1, '0, '0);
    cfg(2'd2, 1'b0, 32'd1000, 1'b1, 1'b0, 32'd40, 1'b0, 1'b0, '0, 2'd2);
    pkt(1'b1, '0, '0);
    check("R3 seed 40", out_field, 32'd40);
    cfg(2'd2, 1'b0, 32'd1000, 1'b0, 1'b0, 32'd7, 1'b0, 1'b0, 32'd7, 2'd2);
    pkt(1'b0, 32'd3, 32'd3);
    check("R5 idle out_valid", {{(W-1){1'b0}}, out_valid}, '0);
    check("R5 idle out_field", out_field, '0);
    cfg(2'd0, 1'b1, '0, 1'b1, 1'b0, '0, 1'b1, 1'b0, '0, 2'd1);
    pkt(1'b1, '0, '0);
    check("R5 state held over idle", out_field, 32'd40);

    clear_state();
    cfg(2'd1, 1'b0, 32'd10, 1'b1, 1'b0, 32'd1, 1'b0, 1'b0, '0, 2'd2);
    s = '0;
    for (int i = 0; i < 25; i++) begin
      s = (s != 32'd10) ? s + 1 : '0;
      pkt(1'b1, '0, '0);
      check($sformatf("R9/R7 wrap step %0d", i), out_field, s);
    end

    clear_state();
    cfg(2'd0, 1'b0, 32'd9, 1'b0, 1'b0, '0, 1'b1, 1'b0, 32'd1, 2'd3);
    s = '0;
    for (int i = 0; i < 25; i++) begin
      pkt(1'b1, 32'(100 + i), '0);
      check($sformatf("R10 sample step %0d", i), out_field, (s == 32'd9) ? 32'(100 + i) : '0);
      s = (s == 32'd9) ? '0 : s + 1;
    end

    clear_state();
    cfg(2'd0, 1'b1, '0, 1'b0, 1'b0, '1, 1'b0, 1'b0, '0, 2'd2);
    pkt(1'b1, '0, '0);
    check("R11 load max", out_field, '1);
    cfg(2'd0, 1'b1, '0, 1'b1, 1'b0, 32'd2, 1'b0, 1'b0, '0, 2'd2);
    pkt(1'b1, '0, '0);
    check("R11 wraps to 1", out_field, 32'd1);

    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    cfg(2'd0, 1'b1, '0, 1'b1, 1'b0, '0, 1'b1, 1'b0, '0, 2'd1);
    pkt(1'b1, '0, '0);
    check("R1 reset clears state", out_field, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule